// File: doc/BRIEF.md
# Delay-Slot Branch Resolution Unit

This block sequences the fetch address of a simple in-order pipeline that has one architectural branch delay slot, and it resolves conditional branches handed to it by the decode stage. Each cycle the decode stage may present one branch, with its form (plain or likely), its condition sense (equal or not-equal), the two already-resolved operand values, the 16-bit offset field and the branch's own address. The block compares the operands, forms the target address and, one clock later, updates the registered fetch address and raises a kill pulse for the slot instruction when it must be discarded.

A plain branch always lets its slot instruction complete. A likely branch lets the slot instruction complete only when the branch is taken. Otherwise the block emits a one-cycle kill pulse that travels with the slot instruction and clears its register-write and memory-write enables. A stall input freezes the fetch address and every piece of resolution state. A branch that arrives directly in another branch's slot is undefined. The block flags it, and the fetch address it produces in that case is not guaranteed.

Top module: `dslot_branch_unit`

## Requirements
- R1: While `rst` is high at a rising edge, the following values are set: `fetch_pc_o` = RESET_PC (default 0x0000_1000), `slot_kill_o` = 0 and `nest_err_o` = 0.
- R2: In a cycle with `stall_i` = 0 and `br_valid_i` = 0, `fetch_pc_o` advances by 4 at the next edge, wrapping modulo 2^32.
- R3: In a cycle with `stall_i` = 1, `fetch_pc_o`, `slot_kill_o` and `nest_err_o` keep their values at the next edge, and any branch presented in that cycle has no effect.
- R4: With `br_sense_ne_i` = 0 a branch is taken exactly when `opa_i` == `opb_i`. With `br_sense_ne_i` = 1 it is taken exactly when they differ.
- R5: A taken branch accepted in cycle t gives `fetch_pc_o` = `br_pc_i` + 4 + (sign-extended `offset_i` multiplied by 4) from cycle t+1, computed modulo 2^32. The offset is relative to the slot address, not to the branch.
- R6: A not-taken branch accepted in cycle t gives `fetch_pc_o` = `br_pc_i` + 8 from cycle t+1. This skips the slot address, which decode is already handling.
- R7: A plain branch (`br_likely_i` = 0) never raises `slot_kill_o` in the following cycle, whether taken or not.
- R8: A likely branch (`br_likely_i` = 1) raises `slot_kill_o` for exactly the cycle after it is accepted when it is not taken, and leaves it low when taken.
- R9: A branch accepted in the cycle right after another accepted branch raises `nest_err_o` for the cycle after it. Branches that are separated by at least one non-branch cycle leave it low.
- R10: After a redirect, sequential advance by 4 continues from the new address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall_i | input | 1 | Holds the fetch address and resolution state |
| br_valid_i | input | 1 | Decode stage holds a conditional branch this cycle |
| br_likely_i | input | 1 | 1 = likely form (slot killed when not taken) |
| br_sense_ne_i | input | 1 | 0 = branch on equal, 1 = branch on not-equal |
| opa_i | input | 32 | First resolved operand |
| opb_i | input | 32 | Second resolved operand |
| offset_i | input | 16 | Signed word offset field |
| br_pc_i | input | 32 | Address of the branch instruction |
| fetch_pc_o | output | 32 | Registered next fetch address |
| slot_kill_o | output | 1 | Kill pulse for the delay-slot instruction |
| nest_err_o | output | 1 | Branch found in a delay slot |

## Verification
Every result of this block passes through exactly one register. The fetch address, kill pulse and nesting flag caused by the inputs of cycle t are therefore due in cycle t+1 and stay there until the next edge. The bench drives one cycle of inputs, waits for the rising edge, and samples all three outputs two nanoseconds after it. It compares them against a model advanced by that one cycle. Because every stimulus cycle is checked at its own due cycle, a result that arrives a cycle early or late shows up as a mismatch at the adjacent check. This covers cases such as a kill pulse that lingers, or a redirect that is followed by a second jump.

// File: rtl/dsb_pkg.sv
package dsb_pkg;

  // How the fetch register moves at the next edge
  typedef enum logic [1:0] {
    SEQ_STEP     = 2'd0,
    SEQ_REDIRECT = 2'd1,
    SEQ_SKIP     = 2'd2,
    SEQ_HOLD     = 2'd3
  } seq_op_e;

  // Branch form presented by decode
  typedef enum logic {
    BR_PLAIN  = 1'b0,
    BR_LIKELY = 1'b1
  } br_form_e;

endpackage

// File: rtl/dsb_cond_cmp.sv
module dsb_cond_cmp #(
  parameter int DATA_W  = 32,
  parameter int CHUNK_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              sense_ne_i,
  output logic              taken_o
);
  localparam int NCHUNK = DATA_W / CHUNK_W;

  logic [NCHUNK-1:0] chunk_eq;

  // Per-slice equality, then a reduction tree across slices
  for (genvar g = 0; g < NCHUNK; g++) begin : g_slice
    assign chunk_eq[g] = (a_i[g*CHUNK_W +: CHUNK_W] == b_i[g*CHUNK_W +: CHUNK_W]);
  end

  logic all_eq;
  assign all_eq  = &chunk_eq;
  assign taken_o = all_eq ^ sense_ne_i;

endmodule

// File: rtl/dsb_target_gen.sv
module dsb_target_gen #(
  parameter int ADDR_W     = 32,
  parameter int OFF_W      = 16,
  parameter int WORD_SHIFT = 2
) (
  input  logic [ADDR_W-1:0] br_pc_i,
  input  logic [OFF_W-1:0]  offset_i,
  output logic [ADDR_W-1:0] target_o,
  output logic [ADDR_W-1:0] skip_o
);
  localparam int EXT_W      = ADDR_W - OFF_W - WORD_SHIFT;
  localparam int INSN_BYTES = 1 << WORD_SHIFT;

  logic [ADDR_W-1:0] slot_pc;
  logic [ADDR_W-1:0] byte_off;

  assign slot_pc  = br_pc_i + ADDR_W'(INSN_BYTES);
  assign byte_off = {{EXT_W{offset_i[OFF_W-1]}}, offset_i, {WORD_SHIFT{1'b0}}};
  assign target_o = slot_pc + byte_off;
  assign skip_o   = slot_pc + ADDR_W'(INSN_BYTES);

endmodule

// File: rtl/dsb_pc_seq.sv
module dsb_pc_seq
  import dsb_pkg::*;
#(
  parameter int              ADDR_W     = 32,
  parameter int              WORD_SHIFT = 2,
  parameter logic [ADDR_W-1:0] RESET_PC = 32'h0000_1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stall_i,
  input  logic              br_valid_i,
  input  br_form_e          form_i,
  input  logic              taken_i,
  input  logic [ADDR_W-1:0] target_i,
  input  logic [ADDR_W-1:0] skip_i,
  output logic [ADDR_W-1:0] fetch_pc_o,
  output logic              slot_kill_o,
  output logic              nest_err_o
);
  localparam int INSN_BYTES = 1 << WORD_SHIFT;

  seq_op_e     op;
  logic        in_slot_q;
  logic [ADDR_W-1:0] pc_d;

  always_comb begin
    if (stall_i)          op = SEQ_HOLD;
    else if (!br_valid_i) op = SEQ_STEP;
    else if (taken_i)     op = SEQ_REDIRECT;
    else                  op = SEQ_SKIP;
  end

  always_comb begin
    case (op)
      SEQ_REDIRECT: pc_d = target_i;
      SEQ_SKIP:     pc_d = skip_i;
      SEQ_HOLD:     pc_d = fetch_pc_o;
      default:      pc_d = fetch_pc_o + ADDR_W'(INSN_BYTES);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fetch_pc_o  <= RESET_PC;
      slot_kill_o <= 1'b0;
      nest_err_o  <= 1'b0;
      in_slot_q   <= 1'b0;
    end else if (op != SEQ_HOLD) begin
      fetch_pc_o  <= pc_d;
      slot_kill_o <= (op == SEQ_SKIP) && (form_i == BR_LIKELY);
      nest_err_o  <= br_valid_i && in_slot_q;
      in_slot_q   <= br_valid_i;
    end
  end

endmodule

// File: rtl/dslot_branch_unit.sv
module dslot_branch_unit
  import dsb_pkg::*;
#(
  parameter int                ADDR_W     = 32,
  parameter int                DATA_W     = 32,
  parameter int                OFF_W      = 16,
  parameter int                WORD_SHIFT = 2,
  parameter int                CHUNK_W    = 8,
  parameter logic [ADDR_W-1:0] RESET_PC   = 32'h0000_1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stall_i,
  input  logic              br_valid_i,
  input  logic              br_likely_i,
  input  logic              br_sense_ne_i,
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  input  logic [OFF_W-1:0]  offset_i,
  input  logic [ADDR_W-1:0] br_pc_i,
  output logic [ADDR_W-1:0] fetch_pc_o,
  output logic              slot_kill_o,
  output logic              nest_err_o
);
  logic              taken;
  logic [ADDR_W-1:0] target_pc;
  logic [ADDR_W-1:0] skip_pc;
  br_form_e          form;

  assign form = br_likely_i ? BR_LIKELY : BR_PLAIN;

  dsb_cond_cmp #(.DATA_W(DATA_W), .CHUNK_W(CHUNK_W)) u_cmp (
    .a_i        (opa_i),
    .b_i        (opb_i),
    .sense_ne_i (br_sense_ne_i),
    .taken_o    (taken)
  );

  dsb_target_gen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .WORD_SHIFT(WORD_SHIFT)) u_tgt (
    .br_pc_i  (br_pc_i),
    .offset_i (offset_i),
    .target_o (target_pc),
    .skip_o   (skip_pc)
  );

  dsb_pc_seq #(.ADDR_W(ADDR_W), .WORD_SHIFT(WORD_SHIFT), .RESET_PC(RESET_PC)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .stall_i     (stall_i),
    .br_valid_i  (br_valid_i),
    .form_i      (form),
    .taken_i     (taken),
    .target_i    (target_pc),
    .skip_i      (skip_pc),
    .fetch_pc_o  (fetch_pc_o),
    .slot_kill_o (slot_kill_o),
    .nest_err_o  (nest_err_o)
  );

endmodule

// File: rtl/dslot_branch_unit_chk.sv
module dslot_branch_unit_chk #(
  parameter int                ADDR_W     = 32,
  parameter int                DATA_W     = 32,
  parameter int                OFF_W      = 16,
  parameter int                WORD_SHIFT = 2,
  parameter logic [ADDR_W-1:0] RESET_PC   = 32'h0000_1000
) (
  input logic              clk,
  input logic              rst,
  input logic              stall_i,
  input logic              br_valid_i,
  input logic              br_likely_i,
  input logic              br_sense_ne_i,
  input logic [DATA_W-1:0] opa_i,
  input logic [DATA_W-1:0] opb_i,
  input logic [OFF_W-1:0]  offset_i,
  input logic [ADDR_W-1:0] br_pc_i,
  input logic [ADDR_W-1:0] fetch_pc_o,
  input logic              slot_kill_o,
  input logic              nest_err_o
);
  localparam int          EXT_W = ADDR_W - OFF_W - WORD_SHIFT;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1 << WORD_SHIFT);

  logic              go_taken;
  logic [ADDR_W-1:0] spec_tgt;
  assign go_taken = (opa_i == opb_i) != br_sense_ne_i;
  assign spec_tgt = br_pc_i + STEP + {{EXT_W{offset_i[OFF_W-1]}}, offset_i, {WORD_SHIFT{1'b0}}};

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (fetch_pc_o == RESET_PC && !slot_kill_o && !nest_err_o));

  a_r2_seq_step: assert property (@(posedge clk) disable iff (rst)
    (!stall_i && !br_valid_i) |=> fetch_pc_o == $past(fetch_pc_o) + STEP);

  a_r3_stall_hold: assert property (@(posedge clk) disable iff (rst)
    stall_i |=> ($stable(fetch_pc_o) && $stable(slot_kill_o) && $stable(nest_err_o)));

  a_r5_redirect: assert property (@(posedge clk) disable iff (rst)
    (!stall_i && br_valid_i && go_taken) |=> fetch_pc_o == $past(spec_tgt));

  a_r6_skip_slot: assert property (@(posedge clk) disable iff (rst)
    (!stall_i && br_valid_i && !go_taken) |=> fetch_pc_o == $past(br_pc_i) + STEP + STEP);

  a_r7_plain_no_kill: assert property (@(posedge clk) disable iff (rst)
    (!stall_i && br_valid_i && !br_likely_i) |=> !slot_kill_o);

  a_r8_likely_kill: assert property (@(posedge clk) disable iff (rst)
    (!stall_i && br_valid_i && br_likely_i) |=> (slot_kill_o == !$past(go_taken)));

  a_r8_kill_single: assert property (@(posedge clk) disable iff (rst)
    (slot_kill_o && !stall_i && !br_valid_i) |=> !slot_kill_o);

  a_r9_err_clear: assert property (@(posedge clk) disable iff (rst)
    (!stall_i && !br_valid_i) |=> !nest_err_o);

endmodule

bind dslot_branch_unit dslot_branch_unit_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_W(OFF_W),
  .WORD_SHIFT(WORD_SHIFT), .RESET_PC(RESET_PC)
) u_chk (
  .clk(clk), .rst(rst), .stall_i(stall_i), .br_valid_i(br_valid_i),
  .br_likely_i(br_likely_i), .br_sense_ne_i(br_sense_ne_i),
  .opa_i(opa_i), .opb_i(opb_i), .offset_i(offset_i), .br_pc_i(br_pc_i),
  .fetch_pc_o(fetch_pc_o), .slot_kill_o(slot_kill_o), .nest_err_o(nest_err_o)
);

// File: tb/dslot_branch_unit_tb.sv
module dslot_branch_unit_tb;
  localparam logic [31:0] RST_PC = 32'h0000_1000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        stall_i = 1'b0;
  logic        br_valid_i = 1'b0;
  logic        br_likely_i = 1'b0;
  logic        br_sense_ne_i = 1'b0;
  logic [31:0] opa_i = '0;
  logic [31:0] opb_i = '0;
  logic [15:0] offset_i = '0;
  logic [31:0] br_pc_i = '0;
  logic [31:0] fetch_pc_o;
  logic        slot_kill_o;
  logic        nest_err_o;

  int n_vec = 0;
  int n_bad = 0;

  // Reference state, advanced from the requirements
  logic [31:0] m_pc = RST_PC;
  logic        m_kill = 1'b0;
  logic        m_err = 1'b0;
  logic        m_slot = 1'b0;

  always #4 clk = ~clk;

  dslot_branch_unit u_dut (
    .clk(clk), .rst(rst), .stall_i(stall_i), .br_valid_i(br_valid_i),
    .br_likely_i(br_likely_i), .br_sense_ne_i(br_sense_ne_i),
    .opa_i(opa_i), .opb_i(opb_i), .offset_i(offset_i), .br_pc_i(br_pc_i),
    .fetch_pc_o(fetch_pc_o), .slot_kill_o(slot_kill_o), .nest_err_o(nest_err_o)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // One cycle: drive, model, wait for edge, sample the due results
  task automatic cyc(input string req, input logic st, input logic v,
                     input logic lk, input logic ne, input logic [31:0] a,
                     input logic [31:0] b, input logic [15:0] off,
                     input logic [31:0] bpc);
    logic tk;
    stall_i = st; br_valid_i = v; br_likely_i = lk; br_sense_ne_i = ne;
    opa_i = a; opb_i = b; offset_i = off; br_pc_i = bpc;
    tk = ne ? (a != b) : (a == b);
    if (!st) begin
      if (v) begin
        m_pc   = tk ? (bpc + 32'd4 + (32'($signed(off)) <<< 2)) : (bpc + 32'd8);
        m_kill = lk && !tk;
        m_err  = m_slot;
        m_slot = 1'b1;
      end else begin
        m_pc   = m_pc + 32'd4;
        m_kill = 1'b0;
        m_err  = 1'b0;
        m_slot = 1'b0;
      end
    end
    @(posedge clk); #2;
    check(req, "fetch_pc", fetch_pc_o, m_pc);
    check(req, "slot_kill", 32'(slot_kill_o), 32'(m_kill));
    check(req, "nest_err", 32'(nest_err_o), 32'(m_err));
  endtask

  task automatic idle(input string req);
    cyc(req, 1'b0, 1'b0, 1'b0, 1'b0, '0, '0, '0, '0);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    @(posedge clk); #2;
    m_pc = RST_PC; m_kill = 1'b0; m_err = 1'b0; m_slot = 1'b0;
    check("R1", "fetch_pc", fetch_pc_o, RST_PC);
    check("R1", "slot_kill", 32'(slot_kill_o), 32'd0);
    check("R1", "nest_err", 32'(nest_err_o), 32'd0);
    rst = 1'b0;
  endtask

  task automatic t_sequential;
    for (int i = 0; i < 4; i++) idle("R2");
  endtask

  task automatic t_plain;
    // equal operands, taken, positive offset; then resume from target
    cyc("R5", 1'b0, 1'b1, 1'b0, 1'b0, 32'd7, 32'd7, 16'h0010, m_pc - 32'd4);
    idle("R10");
    idle("R10");
    // plain not taken: slot still executes, fetch skips it
    cyc("R6", 1'b0, 1'b1, 1'b0, 1'b0, 32'd1, 32'd2, 16'h0040, m_pc - 32'd4);
    idle("R7");
  endtask

  task automatic t_likely;
    // likely taken, backward offset
    cyc("R8", 1'b0, 1'b1, 1'b1, 1'b0, 32'hABCD, 32'hABCD, 16'hFFF8, m_pc - 32'd4);
    idle("R8");
    // likely not taken: one-cycle kill
    cyc("R8", 1'b0, 1'b1, 1'b1, 1'b0, 32'h0, 32'h8000_0000, 16'h0100, m_pc - 32'd4);
    idle("R8");
    idle("R8");
  endtask

  task automatic t_sense_ne;
    // not-equal sense with equal operands: not taken, likely kills
    cyc("R4", 1'b0, 1'b1, 1'b1, 1'b1, 32'h55, 32'h55, 16'h0020, m_pc - 32'd4);
    idle("R4");
    // not-equal sense, single bit differs high: taken
    cyc("R4", 1'b0, 1'b1, 1'b0, 1'b1, 32'h0100_0055, 32'h0000_0055, 16'h0003, m_pc - 32'd4);
    idle("R4");
  endtask

  task automatic t_wrap;
    // most negative offset from a low address wraps modulo 2^32
    cyc("R5", 1'b0, 1'b1, 1'b0, 1'b0, 32'd0, 32'd0, 16'h8000, 32'h0000_0010);
    idle("R10");
  endtask

  task automatic t_stall;
    // branch under stall has no effect
    cyc("R3", 1'b1, 1'b1, 1'b0, 1'b0, 32'd3, 32'd3, 16'h0200, 32'h4000_0000);
    // likely not taken, then stall keeps the kill pulse
    cyc("R8", 1'b0, 1'b1, 1'b1, 1'b0, 32'd1, 32'd9, 16'h0004, m_pc - 32'd4);
    cyc("R3", 1'b1, 1'b0, 1'b0, 1'b0, '0, '0, '0, '0);
    cyc("R3", 1'b1, 1'b0, 1'b0, 1'b0, '0, '0, '0, '0);
    idle("R3");
  endtask

  task automatic t_nested;
    cyc("R9", 1'b0, 1'b1, 1'b0, 1'b0, 32'd0, 32'd0, 16'h0010, m_pc - 32'd4);
    cyc("R9", 1'b0, 1'b1, 1'b0, 1'b0, 32'd0, 32'd1, 16'h0010, m_pc - 32'd4);
    idle("R9");
    // separated branches: no flag
    cyc("R9", 1'b0, 1'b1, 1'b0, 1'b0, 32'd0, 32'd1, 16'h0010, m_pc - 32'd4);
    idle("R9");
    cyc("R9", 1'b0, 1'b1, 1'b0, 1'b0, 32'd0, 32'd1, 16'h0010, m_pc - 32'd4);
    idle("R9");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    @(posedge clk); #2;
    t_reset();
    t_sequential();
    t_plain();
    t_likely();
    t_sense_ne();
    t_wrap();
    t_stall();
    t_nested();
    t_reset();
    idle("R2");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule